// File: doc/BRIEF.md
# Shift-Pair Fusion Decoder

This decode-stage unit takes one fetch granule per cycle from a 64-bit pipeline. A granule is a run of 16-bit halfwords, and the instructions in it are a mix of 2-byte compressed encodings and 4-byte full encodings. The unit walks the granule in program order and splits it into instructions. It looks for a logical left shift by an immediate that is followed directly by a logical right shift by the same immediate on the same register. The pair computes a zero extension of the low bits, so the unit replaces it with a single fused micro-op that one execution cycle can complete. It does not need the two dependent cycles of the shift chain. Every other instruction leaves as an ordinary micro-op that carries its raw encoding.

Pairing is confined to one granule. If a left shift is the last instruction of a granule, it is emitted on its own, and the matching right shift in the next granule is also emitted on its own. Results appear one clock after the granule is presented. The unit also reports how many bytes it consumed, so fetch can resume after a 4-byte instruction that was cut off at the granule end.

Top module: `shift_pair_fuser`

## Requirements
- R1: A full-width left shift is recognised by these fields: bits 6:0 = 0010011, bits 14:12 = 001, bits 31:26 = 0. A full-width right shift uses the same fields with bits 14:12 = 101. For both, the shift amount is bits 25:20, the destination is bits 11:7 and the source is bits 19:15. Two such shifts in a row on one register fuse into one micro-op.
- R2: A compressed left shift is quadrant bits 1:0 = 10 with bits 15:13 = 000. Its register is bits 11:7, used as both source and destination. A compressed right shift is bits 1:0 = 01, bits 15:13 = 100 and bits 11:10 = 00, and its register is x8 plus bits 9:7. For both, the shift amount is {bit 12, bits 6:2}. Pairs made only of compressed shifts (4 bytes) fuse, and so do mixed pairs.
- R3: Each output slot carries its byte offset in the granule and its byte length. A fused slot's length is the sum of both instruction lengths (4, 6 or 8).
- R4: A fused slot carries the destination register, the source register of the left shift, and a kept width of 64 minus the shift amount. The register it writes equals the result of running the two shifts one after the other.
- R5: A pair is not fused when any of these holds: the shift amount is zero, the destination is x0, the two amounts differ, or the right shift does not both read and write the register that the left shift wrote. Such instructions are emitted plain.
- R6: The scan runs in program order, and no instruction belongs to two fusions. After a fused pair, the scan resumes at the instruction after the second shift. Valid slots form a prefix starting at slot 0.
- R7: A left shift in the last position of a granule is emitted plain, and a right shift in the first position of the next granule is also emitted plain. No pairing happens across granules.
- R8: A halfword with bits 1:0 = 11 at the last valid position starts a truncated instruction. It is not emitted, and the consumed byte count stops before it.
- R9: Outputs are registered. They reflect the granule presented at the previous rising edge. With no valid input, no slot is valid, and reset clears every output.
- R10: An instruction that is not a recognised shift passes through as a plain slot with its raw encoding, a kept width of 0 and its own length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A granule is presented this cycle |
| in_bytes | input | NHW*16 | Granule halfwords, little-endian, halfword 0 first |
| in_hw_count | input | HCW | Number of valid halfwords from halfword 0 |
| out_valid | output | 1 | Registered copy of in_valid |
| out_uop_vld | output | NHW | Slot holds a micro-op |
| out_uop_fused | output | NHW | Slot is a fused zero-extend |
| out_uop_rd | output | NHW*5 | Destination register (fused slots) |
| out_uop_rs | output | NHW*5 | Source register (fused slots) |
| out_uop_keep | output | NHW*KW | Kept low-bit width (fused), 0 for plain |
| out_uop_len | output | NHW*4 | Byte length covered by the slot |
| out_uop_off | output | NHW*CW | Byte offset of the slot in the granule |
| out_uop_insn | output | NHW*32 | Raw encoding of a plain slot (compressed in low 16 bits) |
| out_fuse_count | output | HCW | Number of fused slots |
| out_consumed | output | CW | Bytes consumed from the granule |

## Verification
The hardest cases to reach are those where candidate pairs overlap or touch the granule edge. Examples are a left shift followed by two right shifts, two left shifts before one right shift, a left shift in the very last halfword, and a full-width encoding cut in half. Directed granules are built halfword by halfword with an exact valid count to put each of these in place. Random granules then draw shifts from only two registers and four amounts, so pairs that match, nearly match and overlap occur often. Each fused slot is applied to a register model and compared with serial execution of the same instructions.

// File: rtl/shift_pair_fuser.sv
module shift_pair_fuser #(
  parameter int NHW  = 8,
  parameter int XLEN = 64,
  parameter int HCW  = $clog2(NHW + 1),
  parameter int CW   = $clog2(2 * NHW + 1),
  parameter int KW   = $clog2(XLEN + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [NHW*16-1:0]   in_bytes,
  input  logic [HCW-1:0]      in_hw_count,
  output logic                out_valid,
  output logic [NHW-1:0]      out_uop_vld,
  output logic [NHW-1:0]      out_uop_fused,
  output logic [NHW*5-1:0]    out_uop_rd,
  output logic [NHW*5-1:0]    out_uop_rs,
  output logic [NHW*KW-1:0]   out_uop_keep,
  output logic [NHW*4-1:0]    out_uop_len,
  output logic [NHW*CW-1:0]   out_uop_off,
  output logic [NHW*32-1:0]   out_uop_insn,
  output logic [HCW-1:0]      out_fuse_count,
  output logic [CW-1:0]       out_consumed
);
  localparam int IW = $clog2(NHW + 2);

  typedef struct packed {
    logic       sll;
    logic       srl;
    logic [4:0] rd;
    logic [4:0] rs;
    logic [5:0] sh;
  } shf_t;

  function automatic shf_t decode(input logic [31:0] w);
    shf_t r;
    r = '0;
    if (w[1:0] == 2'b11) begin
      r.rd  = w[11:7];
      r.rs  = w[19:15];
      r.sh  = w[25:20];
      r.sll = (w[6:0] == 7'b0010011) && (w[14:12] == 3'b001) && (w[31:26] == 6'd0);
      r.srl = (w[6:0] == 7'b0010011) && (w[14:12] == 3'b101) && (w[31:26] == 6'd0);
    end else if (w[1:0] == 2'b10) begin
      r.rd  = w[11:7];
      r.rs  = w[11:7];
      r.sh  = {w[12], w[6:2]};
      r.sll = (w[15:13] == 3'b000);
    end else if (w[1:0] == 2'b01) begin
      r.rd  = {2'b01, w[9:7]};
      r.rs  = {2'b01, w[9:7]};
      r.sh  = {w[12], w[6:2]};
      r.srl = (w[15:13] == 3'b100) && (w[11:10] == 2'b00);
    end
    return r;
  endfunction

  function automatic logic pair_ok(input shf_t a, input shf_t b);
    return a.sll && b.srl && (a.rd != 5'd0) && (a.sh != 6'd0) &&
           (a.sh == b.sh) && (b.rs == a.rd) && (b.rd == a.rd) &&
           (int'(a.sh) < XLEN);
  endfunction

  logic [15:0] hw [NHW+2];
  for (genvar g = 0; g < NHW + 2; g++) begin : g_hw
    if (g < NHW) begin : g_in
      assign hw[g] = in_bytes[g*16 +: 16];
    end else begin : g_pad
      assign hw[g] = '0;
    end
  end

  logic [NHW-1:0]    n_vld, n_fused;
  logic [NHW*5-1:0]  n_rd, n_rs;
  logic [NHW*KW-1:0] n_keep;
  logic [NHW*4-1:0]  n_len;
  logic [NHW*CW-1:0] n_off;
  logic [NHW*32-1:0] n_insn;
  logic [HCW-1:0]    n_nf;
  logic [CW-1:0]     n_used;

  always_comb begin
    int cur, nx, l1, l2, cnt, nf;
    logic stop;
    logic [31:0] w1, w2;
    shf_t d1, d2;
    n_vld = '0; n_fused = '0; n_rd = '0; n_rs = '0; n_keep = '0;
    n_len = '0; n_off = '0; n_insn = '0;
    cnt = int'(in_hw_count);
    cur = 0; nf = 0; stop = 1'b0;
    w1 = '0; w2 = '0; d1 = '0; d2 = '0; nx = 0; l1 = 0; l2 = 0;
    for (int k = 0; k < NHW; k++) begin
      if (!stop && cur < cnt) begin
        w1 = {hw[IW'(cur + 1)], hw[IW'(cur)]};
        l1 = (w1[1:0] == 2'b11) ? 2 : 1;
        if (l1 == 1) w1[31:16] = '0;
        if (cur + l1 > cnt) begin
          stop = 1'b1;
        end else begin
          nx = cur + l1;
          w2 = {hw[IW'(nx + 1)], hw[IW'(nx)]};
          l2 = (w2[1:0] == 2'b11) ? 2 : 1;
          if (l2 == 1) w2[31:16] = '0;
          d1 = decode(w1);
          d2 = decode(w2);
          n_vld[k] = 1'b1;
          n_off[k*CW +: CW] = CW'(2 * cur);
          if (nx < cnt && nx + l2 <= cnt && pair_ok(d1, d2)) begin
            n_fused[k]         = 1'b1;
            n_rd[k*5 +: 5]     = d1.rd;
            n_rs[k*5 +: 5]     = d1.rs;
            n_keep[k*KW +: KW] = KW'(XLEN - int'(d1.sh));
            n_len[k*4 +: 4]    = 4'(2 * (l1 + l2));
            cur = nx + l2;
            nf  = nf + 1;
          end else begin
            n_insn[k*32 +: 32] = w1;
            n_len[k*4 +: 4]    = 4'(2 * l1);
            cur = nx;
          end
        end
      end
    end
    n_nf   = HCW'(nf);
    n_used = CW'(2 * cur);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_uop_vld <= '0; out_uop_fused <= '0;
      out_uop_rd <= '0; out_uop_rs <= '0; out_uop_keep <= '0;
      out_uop_len <= '0; out_uop_off <= '0; out_uop_insn <= '0;
      out_fuse_count <= '0; out_consumed <= '0;
    end else begin
      out_valid      <= in_valid;
      out_uop_vld    <= in_valid ? n_vld : '0;
      out_uop_fused  <= in_valid ? n_fused : '0;
      out_uop_rd     <= n_rd;
      out_uop_rs     <= n_rs;
      out_uop_keep   <= n_keep;
      out_uop_len    <= n_len;
      out_uop_off    <= n_off;
      out_uop_insn   <= n_insn;
      out_fuse_count <= in_valid ? n_nf : '0;
      out_consumed   <= in_valid ? n_used : '0;
    end
  end

  a_r9_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> (out_uop_vld == '0 && out_consumed == '0 && out_fuse_count == '0));

  a_r6_slot_prefix: assert property (@(posedge clk) disable iff (!rst_n)
    (out_uop_vld & (out_uop_vld + NHW'(1))) == '0);

  a_r8_consumed_bound: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> int'(out_consumed) <= 2 * int'($past(in_hw_count)));

  a_r6_fuse_bound: assert property (@(posedge clk) disable iff (!rst_n)
    2 * int'(out_fuse_count) <= int'($countones(out_uop_vld)) + int'(out_fuse_count));

  for (genvar g = 0; g < NHW; g++) begin : g_chk
    a_r4_keep_range: assert property (@(posedge clk) disable iff (!rst_n)
      (out_uop_vld[g] && out_uop_fused[g]) |->
        (out_uop_keep[g*KW +: KW] != '0 && int'(out_uop_keep[g*KW +: KW]) < XLEN));
    a_r3_fused_len: assert property (@(posedge clk) disable iff (!rst_n)
      (out_uop_vld[g] && out_uop_fused[g]) |->
        (out_uop_len[g*4 +: 4] inside {4'd4, 4'd6, 4'd8}));
    a_r10_plain_fields: assert property (@(posedge clk) disable iff (!rst_n)
      (out_uop_vld[g] && !out_uop_fused[g]) |->
        (out_uop_keep[g*KW +: KW] == '0 && out_uop_len[g*4 +: 4] inside {4'd2, 4'd4}));
  end
endmodule

// File: tb/sim_shift_pair_fuser.sv
`timescale 1ns/1ps
module sim_shift_pair_fuser;
  localparam int NHW = 8, HCW = 4, CW = 5, KW = 7;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;
  logic rst_n, in_valid;
  logic [NHW*16-1:0] in_bytes;
  logic [HCW-1:0] in_hw_count;
  logic out_valid;
  logic [NHW-1:0] o_vld, o_fused;
  logic [NHW*5-1:0] o_rd, o_rs;
  logic [NHW*KW-1:0] o_keep;
  logic [NHW*4-1:0] o_len;
  logic [NHW*CW-1:0] o_off;
  logic [NHW*32-1:0] o_insn;
  logic [HCW-1:0] o_nf;
  logic [CW-1:0] o_used;

  shift_pair_fuser u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bytes(in_bytes),
    .in_hw_count(in_hw_count), .out_valid(out_valid), .out_uop_vld(o_vld),
    .out_uop_fused(o_fused), .out_uop_rd(o_rd), .out_uop_rs(o_rs), .out_uop_keep(o_keep),
    .out_uop_len(o_len), .out_uop_off(o_off), .out_uop_insn(o_insn),
    .out_fuse_count(o_nf), .out_consumed(o_used));

  int n_chk = 0, n_bad = 0;
  logic [15:0] gb [NHW];
  int gn;
  logic [63:0] rf_ref [32];
  logic [63:0] rf_dut [32];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] sll32(input int rd, input int rs, input int sh);
    return {6'd0, 6'(sh), 5'(rs), 3'b001, 5'(rd), 7'b0010011};
  endfunction
  function automatic logic [31:0] srl32(input int rd, input int rs, input int sh);
    return {6'd0, 6'(sh), 5'(rs), 3'b101, 5'(rd), 7'b0010011};
  endfunction
  function automatic logic [15:0] cslli(input int rd, input int sh);
    logic [5:0] s = 6'(sh);
    return {3'b000, s[5], 5'(rd), s[4:0], 2'b10};
  endfunction
  function automatic logic [15:0] csrli(input int rd, input int sh);
    logic [5:0] s = 6'(sh);
    return {3'b100, s[5], 2'b00, 3'(rd - 8), s[4:0], 2'b01};
  endfunction
  localparam logic [31:0] ADD32 = 32'h003100b3;
  localparam logic [15:0] CNOP  = 16'h0001;

  task automatic g_clr(); gn = 0; for (int i = 0; i < NHW; i++) gb[i] = '0; endtask
  task automatic p16(input logic [15:0] h); gb[gn] = h; gn++; endtask
  task automatic p32(input logic [31:0] w); gb[gn] = w[15:0]; gb[gn+1] = w[31:16]; gn += 2; endtask

  task automatic apply(input int cnt);
    @(negedge clk);
    for (int i = 0; i < NHW; i++) in_bytes[i*16 +: 16] = gb[i];
    in_hw_count = HCW'(cnt);
    in_valid = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  function automatic int nslots(); return $countones(o_vld); endfunction
  task automatic chk_fused(input string t, input int k, input int rd, input int rs,
                           input int keep, input int len, input int off);
    chk({t, " fused"}, 64'(o_vld[k] & o_fused[k]), 64'd1);
    chk({t, " rd"}, 64'(o_rd[k*5 +: 5]), 64'(rd));
    chk({t, " rs"}, 64'(o_rs[k*5 +: 5]), 64'(rs));
    chk({t, " keep"}, 64'(o_keep[k*KW +: KW]), 64'(keep));
    chk({t, " len"}, 64'(o_len[k*4 +: 4]), 64'(len));
    chk({t, " off"}, 64'(o_off[k*CW +: CW]), 64'(off));
  endtask
  task automatic chk_plain(input string t, input int k, input logic [31:0] insn,
                           input int len, input int off);
    chk({t, " plain"}, {62'd0, o_vld[k], o_fused[k]}, 64'd2);
    chk({t, " insn"}, 64'(o_insn[k*32 +: 32]), 64'(insn));
    chk({t, " keep"}, 64'(o_keep[k*KW +: KW]), 64'd0);
    chk({t, " len"}, 64'(o_len[k*4 +: 4]), 64'(len));
    chk({t, " off"}, 64'(o_off[k*CW +: CW]), 64'(off));
  endtask

  typedef struct { bit sl, sr; int rd, rs, sh, len; } bd_t;
  function automatic bd_t bdec(input logic [31:0] w);
    bd_t r = '{0, 0, 0, 0, 0, 2};
    if (w[1:0] == 2'b11) begin
      r.len = 4; r.rd = int'(w[11:7]); r.rs = int'(w[19:15]); r.sh = int'(w[25:20]);
      r.sl = w[6:0] == 7'h13 && w[14:12] == 3'd1 && w[31:26] == 0;
      r.sr = w[6:0] == 7'h13 && w[14:12] == 3'd5 && w[31:26] == 0;
    end else if (w[1:0] == 2'b10) begin
      r.rd = int'(w[11:7]); r.rs = r.rd; r.sh = int'({w[12], w[6:2]}); r.sl = w[15:13] == 0;
    end else if (w[1:0] == 2'b01) begin
      r.rd = 8 + int'(w[9:7]); r.rs = r.rd; r.sh = int'({w[12], w[6:2]});
      r.sr = w[15:13] == 3'd4 && w[11:10] == 0;
    end
    return r;
  endfunction
  function automatic logic [63:0] bexec(input bd_t d, input logic [63:0] v);
    return d.sl ? (v << d.sh) : (v >> d.sh);
  endfunction

  task automatic t_reset();
    chk("R9 reset valid", 64'(out_valid), 0);
    chk("R9 reset slots", 64'(o_vld), 0);
    chk("R9 reset consumed", 64'(o_used), 0);
  endtask

  task automatic t_full_pair();
    g_clr(); p32(sll32(8, 8, 16)); p32(srl32(8, 8, 16)); apply(gn);
    chk("R9 out_valid", 64'(out_valid), 1);
    chk("R1 slots", 64'(nslots()), 1);
    chk_fused("R1 R4", 0, 8, 8, 48, 8, 0);
    chk("R1 fuse count", 64'(o_nf), 1);
    chk("R8 consumed", 64'(o_used), 8);
  endtask

  task automatic t_compressed_pair();
    g_clr(); p16(cslli(9, 32)); p16(csrli(9, 32)); p32(ADD32); apply(gn);
    chk("R2 slots", 64'(nslots()), 2);
    chk_fused("R2", 0, 9, 9, 32, 4, 0);
    chk_plain("R10 add", 1, ADD32, 4, 4);
    chk("R2 consumed", 64'(o_used), 8);
  endtask

  task automatic t_mixed();
    g_clr(); p32(sll32(10, 11, 48)); p16(csrli(10, 48));
    p16(cslli(12, 8)); p32(srl32(12, 12, 8)); apply(gn);
    chk("R3 slots", 64'(nslots()), 2);
    chk_fused("R3 R4 first", 0, 10, 11, 16, 6, 0);
    chk_fused("R3 second", 1, 12, 12, 56, 6, 6);
    chk("R3 fuse count", 64'(o_nf), 2);
    chk("R3 consumed", 64'(o_used), 12);
  endtask

  task automatic t_reject();
    logic [31:0] a [4], b [4];
    a[0] = {16'd0, cslli(8, 0)};   b[0] = {16'd0, csrli(8, 0)};
    a[1] = sll32(0, 0, 4);         b[1] = srl32(0, 0, 4);
    a[2] = sll32(8, 8, 16);        b[2] = srl32(8, 8, 17);
    a[3] = sll32(8, 8, 16);        b[3] = srl32(9, 8, 16);
    for (int i = 0; i < 4; i++) begin
      g_clr();
      if (i == 0) begin p16(a[i][15:0]); p16(b[i][15:0]); end
      else begin p32(a[i]); p32(b[i]); end
      apply(gn);
      chk($sformatf("R5 case%0d fuse count", i), 64'(o_nf), 0);
      chk_plain($sformatf("R5 case%0d first", i), 0, a[i], i == 0 ? 2 : 4, 0);
      chk_plain($sformatf("R5 case%0d second", i), 1, b[i], i == 0 ? 2 : 4, i == 0 ? 2 : 4);
    end
  endtask

  task automatic t_chains();
    g_clr(); p16(cslli(8, 16)); p16(csrli(8, 16)); p16(csrli(8, 16)); apply(gn);
    chk("R6 chain a slots", 64'(nslots()), 2);
    chk_fused("R6 chain a", 0, 8, 8, 48, 4, 0);
    chk_plain("R6 chain a tail", 1, {16'd0, csrli(8, 16)}, 2, 4);
    g_clr(); p16(cslli(8, 4)); p16(cslli(8, 4)); p16(csrli(8, 4)); apply(gn);
    chk("R6 chain b slots", 64'(nslots()), 2);
    chk_plain("R6 chain b head", 0, {16'd0, cslli(8, 4)}, 2, 0);
    chk_fused("R6 chain b", 1, 8, 8, 60, 4, 2);
  endtask

  task automatic t_boundary();
    g_clr(); p32(ADD32); p32(ADD32); p32(ADD32); p16(cslli(8, 16)); apply(gn);
    chk("R7 granule A slots", 64'(nslots()), 4);
    chk_plain("R7 last shift", 3, {16'd0, cslli(8, 16)}, 2, 12);
    chk("R7 granule A fuse", 64'(o_nf), 0);
    g_clr(); p16(csrli(8, 16)); p16(CNOP); apply(gn);
    chk_plain("R7 first shift", 0, {16'd0, csrli(8, 16)}, 2, 0);
    chk("R7 granule B fuse", 64'(o_nf), 0);
  endtask

  task automatic t_truncated();
    g_clr(); p16(cslli(8, 16)); p16(16'h0413); apply(gn);
    chk("R8 short slots", 64'(nslots()), 1);
    chk("R8 short consumed", 64'(o_used), 2);
    g_clr(); p32(ADD32); p32(ADD32); p32(ADD32); p16(CNOP); p16(16'h0013); apply(gn);
    chk("R8 full slots", 64'(nslots()), 4);
    chk("R8 full consumed", 64'(o_used), 14);
  endtask

  task automatic t_idle();
    @(negedge clk); @(posedge clk); #1;
    chk("R9 idle valid", 64'(out_valid), 0);
    chk("R9 idle slots", 64'(o_vld), 0);
    g_clr(); apply(0);
    chk("R9 empty slots", 64'(o_vld), 0);
    chk("R9 empty consumed", 64'(o_used), 0);
  endtask

  task automatic t_random();
    logic [31:0] pw [NHW];
    int pn, exp_nf, r, sh, rg;
    for (int i = 0; i < 32; i++) begin
      rf_ref[i] = {$urandom, $urandom}; if (i == 0) rf_ref[i] = '0; rf_dut[i] = rf_ref[i];
    end
    for (int it = 0; it < 300; it++) begin
      g_clr(); pn = 0;
      while (gn < NHW) begin
        r = $urandom_range(0, 9);
        case ($urandom_range(0, 3)) 0: sh = 16; 1: sh = 32; 2: sh = 48; default: sh = 8; endcase
        rg = 8 + $urandom_range(0, 1);
        if (r >= 7 && gn == NHW - 1) r = 9;
        case (r)
          0, 1, 2, 3: begin pw[pn] = {16'd0, cslli(rg, sh)}; p16(pw[pn][15:0]); end
          4, 5, 6:    begin pw[pn] = {16'd0, csrli(rg, sh)}; p16(pw[pn][15:0]); end
          7:          begin pw[pn] = sll32(rg, 8 + $urandom_range(0, 1), sh); p32(pw[pn]); end
          8:          begin pw[pn] = srl32(rg, rg, sh); p32(pw[pn]); end
          default:    begin pw[pn] = {16'd0, CNOP}; p16(CNOP); end
        endcase
        pn++;
      end
      exp_nf = 0;
      for (int i = 0; i < pn; i++) begin
        bd_t d = bdec(pw[i]);
        if (d.sl || d.sr) if (d.rd != 0) rf_ref[d.rd] = bexec(d, rf_ref[d.rs]);
      end
      for (int i = 0; i < pn; i++) begin
        if (i + 1 < pn) begin
          bd_t a = bdec(pw[i]), b = bdec(pw[i+1]);
          if (a.sl && b.sr && a.rd != 0 && a.sh != 0 && a.sh == b.sh && b.rs == a.rd && b.rd == a.rd) begin
            exp_nf++; i++;
          end
        end
      end
      apply(gn);
      for (int k = 0; k < NHW; k++) begin
        if (o_vld[k]) begin
          if (o_fused[k]) begin
            int rd = int'(o_rd[k*5 +: 5]);
            logic [63:0] m = (64'd1 << o_keep[k*KW +: KW]) - 64'd1;
            if (rd != 0) rf_dut[rd] = rf_dut[int'(o_rs[k*5 +: 5])] & m;
          end else begin
            bd_t d = bdec(o_insn[k*32 +: 32]);
            if ((d.sl || d.sr) && d.rd != 0) rf_dut[d.rd] = bexec(d, rf_dut[d.rs]);
          end
        end
      end
      chk("R6 random fuse count", 64'(o_nf), 64'(exp_nf));
      chk("R4 random x8", rf_dut[8], rf_ref[8]);
      chk("R4 random x9", rf_dut[9], rf_ref[9]);
    end
  endtask

  initial begin
    #750000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_bytes = '0; in_hw_count = '0;
    repeat (3) @(posedge clk);
    #1; t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_full_pair();
    t_compressed_pair();
    t_mixed();
    t_reject();
    t_chains();
    t_boundary();
    t_truncated();
    t_idle();
    t_random();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule